// File: doc/BRIEF.md
# Four-Phase Interlocked Bus Read Link

This block carries one read at a time from a requesting side to a memory side over a set of strobe wires that share no timing reference. The requesting side (the initiator) puts an address on the bus, waits a settle interval, pulls its active-low memory-request and read lines low, and then pulls the active-low sync strobe low. The responding side (the responder) notices sync, spends a configurable access time fetching the addressed word, drives the word onto the data lines and only then pulls its active-low acknowledge low. The initiator latches the word once it sees acknowledge and lets sync go high. The responder lets acknowledge go high only after it has seen sync go away. Both sides are clocked state machines, and each one reads the other's strobe through a synchronizer chain of its own. The handshake therefore depends only on the order of edges and never on a fixed cycle count.

A user starts a read by raising `req_valid` while `req_ready` is high. The block answers with a one-cycle `done` pulse and holds the fetched word on `done_data`. The bus wires are brought out as outputs so that the handshake can be watched. The responder's storage is a read-only word generator: the word at an address is a fixed function of that address.

Initiator states: M_IDLE (ready) goes to M_ADDR when a request is accepted. M_ADDR (address driven, settle count running) goes to M_CTRL once the count expires. M_CTRL (request and read low) goes to M_SYNC after one cycle. M_SYNC (sync low) goes to M_RELEASE on a synchronized acknowledge, and the data is latched at that edge. M_RELEASE (all strobes high) goes to M_DONE once acknowledge is seen high again. M_DONE (done pulse) returns to M_IDLE. Responder states: S_IDLE goes to S_FETCH on a synchronized sync. S_FETCH (access count running) goes to S_ACK once the count expires, and the word is captured at that edge. S_ACK (word driven, acknowledge low) returns to S_IDLE once sync is seen high.

Top module: `async_read_link`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. The captured address appears on `bus_addr` and stays unchanged for as long as `mreq_n` is low.
- R2: `mreq_n` and `rd_n` go low SETTLE_CYC cycles after the accepting edge. `syn_n` goes low exactly one cycle after that, and only while both of them are already low.
- R3: The word returned for address a is the low DATA_W bits of (a × 40503) XOR 0x5A5A, for example 0x5A5A for address 0.
- R4: `ack_n` goes low SYNC_STAGES+1+ACCESS_CYC cycles after `syn_n` falls. While `ack_n` is low, `bus_data` carries the R3 word and does not change.
- R5: The initiator latches the data and raises `syn_n`, `mreq_n` and `rd_n` SYNC_STAGES+1 cycles after `ack_n` falls. `ack_n` is still low when `syn_n` rises.
- R6: `ack_n` rises SYNC_STAGES+1 cycles after `syn_n` rises, and never while `syn_n` is low.
- R7: `bus_data` is all zeros whenever `ack_n` is high.
- R8: `req_ready` is low from the accepting edge until the cycle after `done`, so no new request starts before `ack_n` has returned high. A `req_valid` raised while `req_ready` is low is ignored: it changes neither the result nor the bus.
- R9: `done` is a single-cycle pulse that comes SYNC_STAGES+1 cycles after `ack_n` rises. `done_data` then holds the R3 word and keeps it until the next `done`.
- R10: While in reset, `mreq_n`, `rd_n`, `syn_n` and `ack_n` are high, `bus_data` is zero, `req_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both state machines |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request to start a read |
| req_addr | input | ADDR_W | Address to read |
| req_ready | output | 1 | Initiator idle and able to accept a request |
| done | output | 1 | One-cycle pulse when a read completes |
| done_data | output | DATA_W | Last word read |
| bus_addr | output | ADDR_W | Address lines driven by the initiator |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| syn_n | output | 1 | Sync strobe from the initiator, active low |
| ack_n | output | 1 | Acknowledge from the responder, active low |
| bus_data | output | DATA_W | Data lines driven by the responder |

## Verification
The accepting edge is taken as cycle 0. Every strobe event then falls due at a fixed offset from it. The request and read strobes are due after SETTLE_CYC cycles and sync one cycle later. The acknowledge falls SYNC_STAGES+1+ACCESS_CYC cycles after sync falls, and each later crossing (sync rising, acknowledge rising, done) adds SYNC_STAGES+1 cycles. With the default parameters, done is due 18 cycles after acceptance. The bench samples on falling clock edges, records the cycle at which each strobe first changes, and compares each one with these offsets. It also checks the address, the data and the quiet bus on every cycle of each read, for directed and seeded random addresses and gaps.

// File: rtl/arl_pkg.sv
package arl_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_ADDR,
        M_CTRL,
        M_SYNC,
        M_RELEASE,
        M_DONE
    } mst_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_ACK
    } slv_state_t;

endpackage

// File: rtl/arl_strobe_sync.sv
module arl_strobe_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/arl_master.sv
module arl_master
    import arl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SETTLE_CYC  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              syn_n,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] bus_data
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    mst_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ack_seen_n;

    arl_strobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ack_n),
        .dout (ack_seen_n)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == M_IDLE && req_valid) begin
                addr_q <= req_addr;
                cnt_q  <= '0;
            end else if (state_q == M_ADDR) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == M_SYNC && !ack_seen_n) begin
                data_q <= bus_data;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:    if (req_valid)         state_d = M_ADDR;
            M_ADDR:    if (cnt_q == CNT_LAST) state_d = M_CTRL;
            M_CTRL:                           state_d = M_SYNC;
            M_SYNC:    if (!ack_seen_n)       state_d = M_RELEASE;
            M_RELEASE: if (ack_seen_n)        state_d = M_DONE;
            M_DONE:                           state_d = M_IDLE;
            default:                          state_d = M_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        mreq_n    = 1'b1;
        rd_n      = 1'b1;
        syn_n     = 1'b1;
        unique case (state_q)
            M_IDLE:    req_ready = 1'b1;
            M_ADDR:    ;
            M_CTRL: begin
                mreq_n = 1'b0;
                rd_n   = 1'b0;
            end
            M_SYNC: begin
                mreq_n = 1'b0;
                rd_n   = 1'b0;
                syn_n  = 1'b0;
            end
            M_RELEASE: ;
            M_DONE:    done = 1'b1;
            default:   ;
        endcase
    end

    assign bus_addr  = addr_q;
    assign done_data = data_q;

endmodule

// File: rtl/arl_slave.sv
module arl_slave
    import arl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int ACCESS_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              syn_n,
    output logic              ack_n,
    output logic [DATA_W-1:0] bus_data
);

    localparam int CNT_W = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACCESS_CYC - 1);
    localparam logic [31:0] MULT_K = 32'd40503;
    localparam logic [31:0] MIX_K  = 32'h0000_5A5A;

    slv_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] word_q;
    logic              syn_seen_n;
    logic              rd_req;

    function automatic logic [DATA_W-1:0] gen_word(input logic [ADDR_W-1:0] a);
        logic [31:0] prod;
        prod = 32'(a) * MULT_K;
        return DATA_W'(prod ^ MIX_K);
    endfunction

    arl_strobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syn_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (syn_n),
        .dout (syn_seen_n)
    );

    // request and read are settled before sync, so they are sampled directly
    assign rd_req = !syn_seen_n && !mreq_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == S_FETCH) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) word_q <= gen_word(bus_addr);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (rd_req)             state_d = S_FETCH;
            S_FETCH: if (cnt_q == CNT_LAST)  state_d = S_ACK;
            S_ACK:   if (syn_seen_n)         state_d = S_IDLE;
            default:                         state_d = S_IDLE;
        endcase
    end

    always_comb begin
        ack_n    = 1'b1;
        bus_data = '0;
        unique case (state_q)
            S_IDLE:  ;
            S_FETCH: ;
            S_ACK: begin
                ack_n    = 1'b0;
                bus_data = word_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SETTLE_CYC  = 2,
    parameter int ACCESS_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              syn_n,
    output logic              ack_n,
    output logic [DATA_W-1:0] bus_data
);

    arl_master #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SETTLE_CYC (SETTLE_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .done     (done),
        .done_data(done_data),
        .bus_addr (bus_addr),
        .mreq_n   (mreq_n),
        .rd_n     (rd_n),
        .syn_n    (syn_n),
        .ack_n    (ack_n),
        .bus_data (bus_data)
    );

    arl_slave #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ACCESS_CYC (ACCESS_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_addr(bus_addr),
        .mreq_n  (mreq_n),
        .rd_n    (rd_n),
        .syn_n   (syn_n),
        .ack_n   (ack_n),
        .bus_data(bus_data)
    );

endmodule

// File: rtl/async_read_link_chk.sv
module async_read_link_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              mreq_n,
    input logic              rd_n,
    input logic              syn_n,
    input logic              ack_n,
    input logic [DATA_W-1:0] bus_data
);

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && $past(!mreq_n)) |-> $stable(bus_addr)); // R1

    AST_SYN_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syn_n) |-> ($past(!mreq_n) && $past(!rd_n))); // R2

    AST_SYN_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_n |-> (!mreq_n && !rd_n)); // R2

    AST_ACK_NEEDS_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> !syn_n); // R4

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && $past(!ack_n)) |-> $stable(bus_data)); // R4

    AST_SYN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_n) |-> !ack_n); // R5

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |-> syn_n); // R6

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> (bus_data == '0)); // R7

    AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mreq_n) |-> ack_n); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n || !ack_n) |-> !req_ready); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

bind async_read_link async_read_link_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .done     (done),
    .bus_addr (bus_addr),
    .mreq_n   (mreq_n),
    .rd_n     (rd_n),
    .syn_n    (syn_n),
    .ack_n    (ack_n),
    .bus_data (bus_data)
);

// File: tb/async_read_link_bench.sv
`timescale 1ns/1ps
module async_read_link_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int SETTLE = 2;
    localparam int ACCESS = 3;
    localparam int SS = 2;

    localparam int E_MREQ = SETTLE;
    localparam int E_SYN  = SETTLE + 1;
    localparam int E_ACK  = E_SYN + SS + 1 + ACCESS;
    localparam int E_SYNR = E_ACK + SS + 1;
    localparam int E_ACKR = E_SYNR + SS + 1;
    localparam int E_DONE = E_ACKR + SS + 1;
    localparam int WIN    = E_DONE + 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, done, mreq_n, rd_n, syn_n, ack_n;
    logic [DW-1:0] done_data, bus_data;
    logic [AW-1:0] bus_addr;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    async_read_link #(
        .ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SETTLE),
        .ACCESS_CYC(ACCESS), .SYNC_STAGES(SS)
    ) u_async_read_link (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .done(done), .done_data(done_data),
        .bus_addr(bus_addr), .mreq_n(mreq_n), .rd_n(rd_n), .syn_n(syn_n),
        .ack_n(ack_n), .bus_data(bus_data)
    );

    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'd40503;
        return p[DW-1:0] ^ 16'h5A5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            summary();
        end
    end

    // one complete read; poke drives an extra request while busy
    task automatic run_txn(input logic [AW-1:0] a, input bit poke);
        int t_mreq = -1, t_syn = -1, t_ack = -1, t_synr = -1, t_ackr = -1, t_done = -1;
        int n_done = 0;
        bit addr_bad = 0, data_bad = 0, quiet_bad = 0, ready_bad = 0, restart = 0;
        logic [DW-1:0] w;
        w = exp_word(a);
        @(negedge clk);
        chk(req_ready === 1'b1, "R8", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1;
            req_addr  = ~a;
        end
        for (int k = 0; k <= WIN; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == E_DONE - 3) req_valid = 1'b0;
            if (t_mreq < 0 && !mreq_n) t_mreq = k;
            if (t_syn < 0 && !syn_n) t_syn = k;
            if (t_ack < 0 && !ack_n) t_ack = k;
            if (t_syn >= 0 && t_synr < 0 && syn_n) t_synr = k;
            if (t_ack >= 0 && t_ackr < 0 && ack_n) t_ackr = k;
            if (done) begin
                n_done++;
                if (t_done < 0) t_done = k;
            end
            if (!mreq_n && bus_addr !== a) addr_bad = 1;
            if (!ack_n && bus_data !== w) data_bad = 1;
            if (ack_n && bus_data !== '0) quiet_bad = 1;
            if ((k <= E_DONE && req_ready) || (k > E_DONE && !req_ready)) ready_bad = 1;
            if (k > E_DONE && !mreq_n) restart = 1;
        end
        chk(t_mreq == E_MREQ, "R2", "mreq_n fall cycle", t_mreq, E_MREQ);
        chk(t_syn == E_SYN, "R2", "syn_n fall cycle", t_syn, E_SYN);
        chk(!addr_bad, "R1", "address held during request", addr_bad, 0);
        chk(t_ack == E_ACK, "R4", "ack_n fall cycle", t_ack, E_ACK);
        chk(!data_bad, "R3", "bus word while ack_n low", data_bad, 0);
        chk(t_synr == E_SYNR, "R5", "syn_n rise cycle", t_synr, E_SYNR);
        chk(t_ackr == E_ACKR, "R6", "ack_n rise cycle", t_ackr, E_ACKR);
        chk(!quiet_bad, "R7", "bus zero while ack_n high", quiet_bad, 0);
        chk(t_done == E_DONE, "R9", "done cycle", t_done, E_DONE);
        chk(n_done == 1, "R9", "done pulse count", n_done, 1);
        chk(done_data === w, "R9", "done_data word", done_data, w);
        chk(!ready_bad, "R8", "ready window", ready_bad, 0);
        chk(!restart, "R8", "no extra request started", restart, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(mreq_n === 1'b1 && rd_n === 1'b1, "R10", "request strobes in reset", {mreq_n, rd_n}, 3);
        chk(syn_n === 1'b1 && ack_n === 1'b1, "R10", "sync/ack in reset", {syn_n, ack_n}, 3);
        chk(bus_data === '0, "R10", "bus_data in reset", bus_data, 0);
        chk(req_ready === 1'b1 && done === 1'b0, "R10", "ready/done in reset", {req_ready, done}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_txn(8'h00, 1'b0);
        run_txn(8'hFF, 1'b0);
        run_txn(8'h5C, 1'b1);
        chk(done_data === exp_word(8'h5C), "R8", "poked request ignored", done_data, exp_word(8'h5C));
        run_txn(8'h01, 1'b0);
        for (int i = 0; i < 30; i++) begin
            int gap;
            logic [AW-1:0] a;
            gap = int'($urandom_range(0, 3));
            a = AW'($urandom);
            repeat (gap) @(negedge clk);
            run_txn(a, ($urandom_range(0, 4) == 0));
        end
        summary();
    end

endmodule